// File: doc/BRIEF.md
# Periodic Interrupt Generator for a Real-Time Clock

This block derives the periodic interrupt of a CMOS-style real-time clock from a 32768 Hz time base. The time base arrives as a one-cycle enable strobe in the system clock domain. A free-running strobe counter runs from reset. A four-bit rate code selects a power-of-two period, and a tick fires whenever the strobe count lands on a multiple of that period. Each tick sets two flags in a status register and raises an interrupt line.

Software programs the rate code and a small control register through a write port. It takes the interrupt by reading the status register, and that read also clears it. A legacy-mode input blocks the interrupt from being raised, but never from being lowered. An optional coalescing mode counts ticks that arrive while the flags are still pending. It later replays them: each read-clear re-raises the interrupt once. The replay count is rescaled whenever the period changes, so that it keeps expressing elapsed time.

Top module: `rtc_pirq_gen`

## Requirements
- R1: The rate code is written at address 0, bits 3:0. A code of 0 produces no tick at all.
- R2: Rate codes 3 to 15 give a period of 2^(code-1) strobes.
- R3: Rate codes 1 and 2 are treated as 8 and 9, which gives periods of 128 and 256 strobes.
- R4: A tick occurs on the strobe that brings the strobe count since reset to a multiple of the period. After the timer is started, the first tick therefore falls on the next such multiple, whatever the gaps between strobes.
- R5: The control register is written at address 1. Bit 0 is the periodic enable, bit 1 the square-wave enable, and bit 2 the square-wave interrupt select. The timer runs when the code is nonzero and either bit 0 is set with legacy mode low, or bits 1 and 2 are both set.
- R6: A tick sets status bits 7 and 6 and drives `irq` high, both visible right after the clock edge that carries the strobe.
- R7: While `legacy_mode` is high, `irq` never rises. A tick on the square-wave path still sets the status flags, and a read-clear still lowers `irq`.
- R8: `rd_data` shows the status register combinationally. A cycle with `rd_stat` high clears the status and lowers `irq` at that clock edge.
- R9: With control bit 3 (coalescing) set, a tick that meets still-pending flags increments a missed-tick count instead. Each read-clear made while that count is nonzero sets the flags again, raises `irq` and decrements the count. With bit 3 clear, such ticks are not counted.
- R10: The missed-tick count saturates at 2^MISS_W-1 and does not wrap.
- R11: When the period changes while the timer runs, the count becomes count × old period / new period, saturating.
- R12: The missed-tick count is cleared whenever the timer stops.
- R13: A tick and a read-clear in the same cycle: the tick wins. The flags end up set, `irq` ends up high, and no missed tick is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_32k | input | 1 | One-cycle strobe at 32768 Hz |
| legacy_mode | input | 1 | Blocks raising of the interrupt |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 rate, 1 control |
| wr_data | input | 8 | Register write data |
| rd_stat | input | 1 | Status read with clear |
| rd_data | output | 8 | Status register value (bits 7 and 6 are flags) |
| irq | output | 1 | Periodic interrupt line |

## Verification
A period tick and a status read-clear can land on the same clock edge. Both of them write the flags, the interrupt line and the missed-tick count. The bench tracks the strobe count itself. It raises `rd_stat` together with exactly the strobe that completes a period, while coalescing is on and the flags are still pending from the previous tick. It judges the result by three observations: the read value before the edge, the interrupt line after it, and a drain of read-clears that must replay no ticks.

// File: rtl/rtc_pirq_pkg.sv
package rtc_pirq_pkg;

  localparam int RATE_W = 4;

  localparam logic [1:0] ADDR_RATE = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;

  localparam logic [7:0] FLAG_MASK = 8'hC0;

  typedef struct packed {
    logic coal_en;
    logic sqw_irq_sel;
    logic sqw_en;
    logic per_en;
  } ctrl_t;

  // Shift amount (log2 of the period) for a nonzero rate code.
  function automatic logic [RATE_W-1:0] rate_to_shift(input logic [RATE_W-1:0] code);
    logic [RATE_W-1:0] eff;
    eff = (code <= RATE_W'(2)) ? code + RATE_W'(7) : code;
    return eff - RATE_W'(1);
  endfunction

endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [RATE_W-1:0] rate_o,
  output ctrl_t             ctrl_o
);

  logic [RATE_W-1:0] rate_q, rate_nx;
  ctrl_t             ctrl_q, ctrl_nx;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:RATE_W];

  always_comb begin
    rate_nx = rate_q;
    ctrl_nx = ctrl_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_RATE: rate_nx = wr_data[RATE_W-1:0];
        ADDR_CTRL: ctrl_nx = ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      rate_q <= rate_nx;
      ctrl_q <= ctrl_nx;
    end
  end

  assign rate_o = rate_q;
  assign ctrl_o = ctrl_q;

  // R1
  rate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_RATE) |=> rate_q == $past(wr_data[RATE_W-1:0]));

endmodule

// File: rtl/rtc_rate_timer.sv
module rtc_rate_timer
  import rtc_pirq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [RATE_W-1:0] shift_o,
  output logic              tick_o
);

  logic [CNT_W-1:0]  cnt_q, cnt_nx, mask;
  logic [RATE_W-1:0] shift;

  always_comb begin
    shift  = rate_to_shift(rate_i);
    mask   = (CNT_W'(1) << shift) - CNT_W'(1);
    cnt_nx = strobe_i ? cnt_q + CNT_W'(1) : cnt_q;
    tick_o = strobe_i && run_i && ((cnt_nx & mask) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (strobe_i) begin
      cnt_q <= cnt_nx;
    end
  end

  assign shift_o = shift;

  // R4
  tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> ((cnt_q & $past(mask)) == '0));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R1
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |-> !tick_o);

endmodule

// File: rtl/rtc_coalesce.sv
module rtc_coalesce
  import rtc_pirq_pkg::*;
#(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [RATE_W-1:0] shift_i,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic              nz_o
);

  localparam logic [MISS_W-1:0] CNT_MAX = '1;
  localparam int                MAX_SH  = (1 << RATE_W) - 1;

  logic [MISS_W-1:0] cnt_q, cnt_nx, scaled;
  logic [RATE_W-1:0] shift_q, shift_nx, diff;
  logic              sat;

  // Rescale by old period / new period; periods are powers of two.
  always_comb begin
    scaled = cnt_q;
    sat    = 1'b0;
    diff   = '0;
    if (shift_i > shift_q) begin
      diff   = shift_i - shift_q;
      scaled = cnt_q >> diff;
    end else if (shift_i < shift_q) begin
      diff = shift_q - shift_i;
      for (int i = 0; i < MAX_SH; i++) begin
        if (i < int'(diff)) begin
          if (scaled[MISS_W-1]) sat = 1'b1;
          scaled = scaled << 1;
        end
      end
      if (sat) scaled = CNT_MAX;
    end
  end

  always_comb begin
    cnt_nx   = scaled;
    shift_nx = shift_i;
    if (!run_i) begin
      cnt_nx   = '0;
      shift_nx = shift_q;
    end else if (inc_i) begin
      cnt_nx = (scaled == CNT_MAX) ? CNT_MAX : scaled + MISS_W'(1);
    end else if (dec_i && scaled != '0) begin
      cnt_nx = scaled - MISS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      cnt_q   <= cnt_nx;
      shift_q <= shift_nx;
    end
  end

  assign nz_o = (cnt_q != '0);

  // R12
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && inc_i && cnt_q == CNT_MAX && shift_i == shift_q) |=> cnt_q == CNT_MAX);

  // R11
  halve_on_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !inc_i && !dec_i && shift_i == shift_q + RATE_W'(1))
      |=> cnt_q == ($past(cnt_q) >> 1));

  // R9
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && inc_i && cnt_q != CNT_MAX && shift_i == shift_q)
      |=> cnt_q == $past(cnt_q) + MISS_W'(1));

endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rd_i,
  input  logic       legacy_i,
  input  logic       coal_i,
  input  logic       miss_nz_i,
  output logic [7:0] status_o,
  output logic       irq_o,
  output logic       miss_inc_o,
  output logic       miss_dec_o
);

  logic [7:0] status_q, status_nx, base_s;
  logic       irq_q, irq_nx, base_irq, pending;

  always_comb begin
    pending    = (status_q[7:6] != 2'b00) && !rd_i;
    base_s     = rd_i ? 8'h00 : status_q;
    base_irq   = rd_i ? 1'b0 : irq_q;
    status_nx  = status_q;
    irq_nx     = irq_q;
    miss_inc_o = 1'b0;
    miss_dec_o = 1'b0;
    if (tick_i) begin
      if (coal_i && pending) begin
        miss_inc_o = 1'b1;
      end else begin
        status_nx = base_s | FLAG_MASK;
        irq_nx    = base_irq | !legacy_i;
      end
    end else if (rd_i) begin
      status_nx = 8'h00;
      irq_nx    = 1'b0;
      if (miss_nz_i && !legacy_i) begin
        status_nx  = FLAG_MASK;
        irq_nx     = 1'b1;
        miss_dec_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 8'h00;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_nx;
      irq_q    <= irq_nx;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R6
  tick_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> status_q[7:6] == 2'b11);

  // R7
  no_raise_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> !$past(legacy_i));

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !tick_i && !miss_nz_i) |=> (status_q == 8'h00 && !irq_q));

  // R13
  tick_beats_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && rd_i && !legacy_i) |=> (irq_q && status_q[7:6] == 2'b11));

endmodule

// File: rtl/rtc_pirq_gen.sv
module rtc_pirq_gen
  import rtc_pirq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MISS_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       legacy_mode,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_stat,
  output logic [7:0] rd_data,
  output logic       irq
);

  logic [RATE_W-1:0] rate, shift;
  ctrl_t             ctrl;
  logic              run, tick, miss_inc, miss_dec, miss_nz;

  rtc_regs #(.DATA_W(8)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rate_o  (rate),
    .ctrl_o  (ctrl)
  );

  assign run = (rate != '0) &&
               ((ctrl.per_en && !legacy_mode) || (ctrl.sqw_en && ctrl.sqw_irq_sel));

  rtc_rate_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (tick_32k),
    .run_i    (run),
    .rate_i   (rate),
    .shift_o  (shift),
    .tick_o   (tick)
  );

  rtc_coalesce #(.MISS_W(MISS_W)) u_coal (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .shift_i (shift),
    .inc_i   (miss_inc),
    .dec_i   (miss_dec),
    .nz_o    (miss_nz)
  );

  rtc_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .rd_i       (rd_stat),
    .legacy_i   (legacy_mode),
    .coal_i     (ctrl.coal_en),
    .miss_nz_i  (miss_nz),
    .status_o   (rd_data),
    .irq_o      (irq),
    .miss_inc_o (miss_inc),
    .miss_dec_o (miss_dec)
  );

  // R5
  stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

endmodule

// File: tb/sim_rtc_pirq_gen.sv
module sim_rtc_pirq_gen;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       legacy_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_stat = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int scount = 0;
  logic [7:0] last_rd;
  bit done = 1'b0;

  rtc_pirq_gen #(.CNT_W(16), .MISS_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .legacy_mode(legacy_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stat(rd_stat), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit s, input bit r);
    tick_32k = s;
    rd_stat  = r;
    #1 last_rd = rd_data;
    @(posedge clk);
    if (s) scount++;
    @(negedge clk);
    tick_32k = 1'b0;
    rd_stat  = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic until_irq(input int maxn);
    for (int i = 0; i < maxn; i++) begin
      cyc(1'b1, 1'b0);
      if (irq) break;
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
  endtask

  // Count read-clears that re-raise the interrupt.
  task automatic drain(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1'b0, 1'b1);
      if (irq) n++;
      else break;
    end
  endtask

  // Stop the timer (clears missed count) and clear status, then start at a code.
  task automatic restart(input logic [7:0] ctrl, input logic [3:0] code);
    wr(2'd0, 8'd0);
    cyc(1'b0, 1'b1);
    wr(2'd1, ctrl);
    wr(2'd0, {4'd0, code});
  endtask

  function automatic int period_of(input int c);
    int e;
    e = (c <= 2) ? c + 7 : c;
    return 1 << (e - 1);
  endfunction

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, s0, ex, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0 && rd_data == 8'h00, "reset R8", int'(rd_data), 0);

    // Sweep every rate code with the periodic enable.
    wr(2'd1, 8'h01);
    for (int c = 0; c < 16; c++) begin
      wr(2'd0, 8'd0);
      cyc(1'b0, 1'b1);
      wr(2'd0, 8'(c));
      if (c == 0) begin
        strobes(64);
        chk(irq == 1'b0 && rd_data == 8'h00, "R1 code zero", int'(irq), 0);
      end else begin
        p  = period_of(c);
        s0 = scount;
        ex = (s0 / p + 1) * p;
        until_irq(2 * p + 2);
        chk(scount == ex, (c <= 2) ? "R3 first tick" : "R4 first tick", scount, ex);
        chk(rd_data == 8'hC0, "R6 flags", int'(rd_data), 8'hC0);
        cyc(1'b0, 1'b1);
        chk(last_rd == 8'hC0 && irq == 1'b0, "R8 read clear", int'(irq), 0);
        until_irq(2 * p + 2);
        chk(scount == ex + p, (c <= 2) ? "R3 period" : "R2 period", scount - ex, p);
        cyc(1'b0, 1'b1);
      end
    end

    // R4: strobes with gaps, alignment follows strobe count.
    restart(8'h01, 4'd3);
    s0 = scount;
    ex = (s0 / 4 + 1) * 4;
    for (int i = 0; i < 40; i++) begin
      cyc(i % 3 == 0, 1'b0);
      if (irq) break;
    end
    chk(scount == ex, "R4 gapped strobes", scount, ex);
    cyc(1'b0, 1'b1);

    // R5: enable combinations.
    restart(8'h02, 4'd3);
    strobes(16);
    chk(irq == 1'b0, "R5 square-wave without select", int'(irq), 0);
    restart(8'h06, 4'd3);
    until_irq(10);
    chk(irq == 1'b1, "R5 square-wave with select", int'(irq), 1);
    restart(8'h00, 4'd3);
    strobes(16);
    chk(irq == 1'b0, "R5 all disabled", int'(irq), 0);

    // R7: legacy mode.
    legacy_mode = 1'b1;
    restart(8'h01, 4'd3);
    strobes(16);
    chk(irq == 1'b0 && rd_data == 8'h00, "R7 periodic path off", int'(rd_data), 0);
    restart(8'h07, 4'd3);
    strobes(8);
    chk(irq == 1'b0 && rd_data == 8'hC0, "R7 flags without irq", int'(rd_data), 8'hC0);
    legacy_mode = 1'b0;
    restart(8'h01, 4'd3);
    until_irq(10);
    legacy_mode = 1'b1;
    cyc(1'b0, 1'b1);
    chk(irq == 1'b0, "R7 lowering allowed", int'(irq), 0);
    legacy_mode = 1'b0;

    // R9: without coalescing, extra ticks are not counted.
    restart(8'h01, 4'd3);
    until_irq(10);
    strobes(12);
    drain(n);
    chk(n == 0, "R9 no count without coalescing", n, 0);

    // R9: coalescing counts three missed ticks.
    restart(8'h09, 4'd3);
    until_irq(10);
    strobes(12);
    drain(n);
    chk(n == 3, "R9 replayed ticks", n, 3);

    // R10: saturation at 15 with a four-bit counter.
    restart(8'h09, 4'd3);
    until_irq(10);
    strobes(80);
    drain(n);
    chk(n == 15, "R10 saturation", n, 15);

    // R11: slower rate halves the count (3 * 4 / 8 = 1).
    restart(8'h09, 4'd3);
    until_irq(10);
    strobes(12);
    wr(2'd0, 8'd4);
    drain(n);
    chk(n == 1, "R11 rescale down", n, 1);

    // R11: faster rate doubles the count (5 * 8 / 4 = 10).
    restart(8'h09, 4'd4);
    until_irq(20);
    strobes(40);
    wr(2'd0, 8'd3);
    drain(n);
    chk(n == 10, "R11 rescale up", n, 10);

    // R11 with R10: 12 * 2 saturates at 15.
    restart(8'h09, 4'd4);
    until_irq(20);
    strobes(96);
    wr(2'd0, 8'd3);
    drain(n);
    chk(n == 15, "R11 rescale saturates", n, 15);

    // R12: stopping the timer clears the count.
    restart(8'h09, 4'd3);
    until_irq(10);
    strobes(12);
    wr(2'd0, 8'd0);
    wr(2'd0, 8'd3);
    drain(n);
    chk(n == 0, "R12 cleared on stop", n, 0);

    // R13: tick and read-clear on the same edge.
    restart(8'h09, 4'd3);
    until_irq(10);
    while ((scount + 1) % 4 != 0) cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
    chk(last_rd == 8'hC0, "R13 value before edge", int'(last_rd), 8'hC0);
    chk(irq == 1'b1 && rd_data == 8'hC0, "R13 tick wins", int'(irq), 1);
    drain(n);
    chk(n == 0, "R13 no missed tick", n, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule